// File: doc/BRIEF.md
# Voice Key Control Register File

This block is the control-register front end of an eight-voice sound processor. A host reaches it through one address port, one write-data port and one combinational read-data port. The 128 byte locations act as plain storage, except for four registers with side effects: a key-on mask, a key-off mask, an end-flag mask and a global flag byte. Writes to these registers drive a small state machine in each voice. The voices emit one-cycle start and release pulses to the playback datapath and report which of them are currently keyed.

Each voice state machine has three states. In `V_IDLE` the voice is silent. In `V_KEYED` it is playing. In `V_PENDING` a key-on has arrived while the voice's key-off bit was set, and the key-on is held. The named transitions are as follows. **kon_start** (IDLE or KEYED to KEYED) is a key-on with the key-off bit clear. **kon_defer** (IDLE or PENDING to PENDING) is a key-on with the key-off bit set. **koff_release** (KEYED to IDLE) is a key-off write with the voice's bit set. **koff_resume** (PENDING to KEYED) is a key-off write with the voice's bit clear. **soft_reset** (any state to IDLE) is a flag write with the soft-reset bit set. The playback datapath reports the end of a voice's sample with a pulse on `voice_end`, and that pulse sets the voice's end flag.

Top module: `voice_key_ctrl`

## Requirements
- R1: After reset the key-on (0x4C), key-off (0x5C) and end-flag (0x7C) registers read 0x00, the flag register (0x6C) reads 0x60, all other locations read 0x00, no voice is keyed and no pulse is high.
- R2: Reads return the location addressed by `reg_addr[6:0]`. A write with `reg_addr[7]` set stores nothing and has no effect on any voice.
- R3: A write to any location other than the four key registers stores the byte, and later reads return it.
- R4: A key-on write with bit n set while key-off bit n is clear pulses `voice_start[n]` in the cycle after the write, marks voice n keyed and clears end-flag bit n. The key-on register stores the written byte.
- R5: A key-on write with bit n set while key-off bit n is set produces no start pulse and leaves voice n not keyed, with its key-on held pending.
- R6: A key-off write with bit n set while voice n is keyed pulses `voice_release[n]` in the cycle after the write, clears the keyed status and clears key-on bit n.
- R7: A key-off write with bit n clear while voice n is pending pulses `voice_start[n]`, marks voice n keyed and clears end-flag bit n. Key-off bit n reads 0 afterwards.
- R8: A key-off write stores the written byte in the key-off register.
- R9: A write to the end-flag register stores 0x00 whatever the data.
- R10: A `voice_end[n]` pulse sets end-flag bit n. It takes priority over any clear of that bit in the same cycle.
- R11: A flag write with bit 7 (soft reset) set stores 0x60 OR data[4:0], where bit 6 is mute and bit 5 is echo-disable. It also clears the key-on, key-off and end-flag registers, returns every voice to idle and pulses `voice_release` on all eight voices.
- R12: A flag write with bit 7 clear stores the byte unchanged.
- R13: Start and release pulses last one cycle unless the next write retriggers them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for the addressed location |
| reg_addr | input | 8 | Register address; bit 7 blocks writes |
| wr_data | input | 8 | Write data |
| voice_end | input | 8 | Per-voice end-of-sample pulses |
| rd_data | output | 8 | Contents of location reg_addr[6:0] |
| voice_start | output | 8 | One-cycle start pulse per voice |
| voice_release | output | 8 | One-cycle release pulse per voice |
| voice_keyed | output | 8 | Per-voice keyed status |

## Verification
The bench targets the deferred key-on. A design that ignored the key-off bit would start the voice at once. A design that dropped the pending state would never start the voice when key-off is later cleared. The bench also collides an end pulse with a start and with an end-flag write; a design with the wrong priority loses the flag. Soft reset is exercised with voices keyed and pending, to catch key-on or key-off bits left over, a missing release pulse or an unforced mute bit. High-address writes are checked for side effects on the aliased low location.

// File: rtl/voice_key_pkg.sv
package voice_key_pkg;
    localparam logic [6:0] KON_ADDR  = 7'h4C;
    localparam logic [6:0] KOFF_ADDR = 7'h5C;
    localparam logic [6:0] FLG_ADDR  = 7'h6C;
    localparam logic [6:0] ENDX_ADDR = 7'h7C;

    localparam int FLG_SOFT_BIT = 7;
    localparam int FLG_MUTE_BIT = 6;
    localparam int FLG_ECHO_BIT = 5;
    localparam logic [7:0] FLG_RESET = 8'h60;

    typedef enum logic [1:0] {
        V_IDLE    = 2'd0,
        V_KEYED   = 2'd1,
        V_PENDING = 2'd2
    } voice_state_e;
endpackage

// File: rtl/key_reg_array.sv
module key_reg_array #(
    parameter int AW = 7,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/voice_fsm.sv
module voice_fsm
    import voice_key_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic kon_wr,
    input  logic koff_wr,
    input  logic soft_rst,
    input  logic wr_bit,
    input  logic koff_bit,
    output logic start_now,
    output logic rel_now,
    output logic start_pulse,
    output logic rel_pulse,
    output logic keyed
);
    voice_state_e st_q, st_d;

    // next-state and same-cycle effects
    always_comb begin
        st_d      = st_q;
        start_now = 1'b0;
        rel_now   = 1'b0;
        if (soft_rst) begin
            st_d    = V_IDLE;                 // soft_reset
            rel_now = 1'b1;
        end else if (kon_wr && wr_bit) begin
            if (!koff_bit) begin
                st_d      = V_KEYED;          // kon_start
                start_now = 1'b1;
            end else begin
                st_d = V_PENDING;             // kon_defer
            end
        end else if (koff_wr) begin
            unique case (st_q)
                V_KEYED: if (wr_bit) begin
                    st_d    = V_IDLE;         // koff_release
                    rel_now = 1'b1;
                end
                V_PENDING: if (!wr_bit) begin
                    st_d      = V_KEYED;      // koff_resume
                    start_now = 1'b1;
                end
                default: st_d = st_q;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= V_IDLE;
        else        st_q <= st_d;
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_pulse <= 1'b0;
            rel_pulse   <= 1'b0;
        end else begin
            start_pulse <= start_now;
            rel_pulse   <= rel_now;
        end
    end

    assign keyed = (st_q == V_KEYED);

    a_r5_pending_has_koff: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == V_PENDING) |-> koff_bit);
    a_r4_keyed_no_koff: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == V_KEYED) |-> !koff_bit);
    a_r4_start_means_keyed: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |-> keyed);
    a_r6_release_means_idle: assert property (@(posedge clk) disable iff (!rst_n)
        rel_pulse |-> !keyed);
endmodule

// File: rtl/voice_key_ctrl.sv
module voice_key_ctrl
    import voice_key_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [DATA_W-1:0] voice_end,
    output logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] voice_start,
    output logic [DATA_W-1:0] voice_release,
    output logic [DATA_W-1:0] voice_keyed
);
    localparam int REG_AW = ADDR_W - 1;
    localparam int NV     = DATA_W;

    logic [REG_AW-1:0] loc;
    logic              wr_ok, hit_kon, hit_koff, hit_flg, hit_endx, soft_rst, gen_wr;
    logic [NV-1:0]     kon_q, koff_q, endx_q, endx_d;
    logic [DATA_W-1:0] flg_q, arr_rd;
    logic [NV-1:0]     start_now, rel_now;

    assign loc      = reg_addr[REG_AW-1:0];
    assign wr_ok    = wr_en && !reg_addr[ADDR_W-1];
    assign hit_kon  = wr_ok && (loc == REG_AW'(KON_ADDR));
    assign hit_koff = wr_ok && (loc == REG_AW'(KOFF_ADDR));
    assign hit_flg  = wr_ok && (loc == REG_AW'(FLG_ADDR));
    assign hit_endx = wr_ok && (loc == REG_AW'(ENDX_ADDR));
    assign soft_rst = hit_flg && wr_data[FLG_SOFT_BIT];
    assign gen_wr   = wr_ok && !(hit_kon || hit_koff || hit_flg || hit_endx);

    key_reg_array #(.AW(REG_AW), .DW(DATA_W)) u_arr (
        .clk(clk), .rst_n(rst_n), .we(gen_wr), .waddr(loc),
        .wdata(wr_data), .raddr(loc), .rdata(arr_rd)
    );

    for (genvar v = 0; v < NV; v++) begin : g_voice
        voice_fsm u_fsm (
            .clk(clk), .rst_n(rst_n),
            .kon_wr(hit_kon), .koff_wr(hit_koff), .soft_rst(soft_rst),
            .wr_bit(wr_data[v]), .koff_bit(koff_q[v]),
            .start_now(start_now[v]), .rel_now(rel_now[v]),
            .start_pulse(voice_start[v]), .rel_pulse(voice_release[v]),
            .keyed(voice_keyed[v])
        );
    end

    // end flags: clears first, end events win
    always_comb begin
        endx_d = (hit_endx || soft_rst) ? '0 : endx_q;
        endx_d = (endx_d & ~start_now) | voice_end;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kon_q  <= '0;
            koff_q <= '0;
            endx_q <= '0;
            flg_q  <= DATA_W'(FLG_RESET);
        end else begin
            endx_q <= endx_d;
            if (hit_kon) kon_q <= wr_data;
            if (hit_koff) begin
                koff_q <= wr_data;
                kon_q  <= kon_q & ~rel_now;
            end
            if (hit_flg) begin
                if (soft_rst) begin
                    flg_q  <= DATA_W'(FLG_RESET) | {{(DATA_W-5){1'b0}}, wr_data[4:0]};
                    kon_q  <= '0;
                    koff_q <= '0;
                end else begin
                    flg_q <= wr_data;
                end
            end
        end
    end

    always_comb begin
        case (loc)
            REG_AW'(KON_ADDR):  rd_data = kon_q;
            REG_AW'(KOFF_ADDR): rd_data = koff_q;
            REG_AW'(FLG_ADDR):  rd_data = flg_q;
            REG_AW'(ENDX_ADDR): rd_data = endx_q;
            default:            rd_data = arr_rd;
        endcase
    end

    a_r2_high_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_addr[ADDR_W-1]) |=>
        ($stable(kon_q) && $stable(koff_q) && $stable(flg_q) && $stable(voice_keyed)));
    a_r11_soft_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (kon_q == '0 && koff_q == '0 && voice_keyed == '0 &&
                      flg_q[FLG_MUTE_BIT] && flg_q[FLG_ECHO_BIT] && voice_release == '1));
    a_r9_endx_write_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_endx && voice_end == '0) |=> (endx_q == '0));
    a_r10_end_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (voice_end != '0) |=> ((endx_q & $past(voice_end)) == $past(voice_end)));
endmodule

// File: tb/sim_voice_key_ctrl.sv
module sim_voice_key_ctrl;
    localparam logic [7:0] A_KON = 8'h4C, A_KOFF = 8'h5C, A_FLG = 8'h6C, A_ENDX = 8'h7C;

    logic       clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
    logic [7:0] reg_addr = 8'h00, wr_data = 8'h00, voice_end = 8'h00;
    logic [7:0] rd_data, voice_start, voice_release, voice_keyed;

    voice_key_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_addr(reg_addr),
        .wr_data(wr_data), .voice_end(voice_end), .rd_data(rd_data),
        .voice_start(voice_start), .voice_release(voice_release),
        .voice_keyed(voice_keyed)
    );

    always #5 clk = ~clk;

    int checks = 0, fails = 0;
    bit done = 1'b0;

    // reference model state (0 idle, 1 keyed, 2 pending)
    logic [7:0] m_reg [128];
    logic [7:0] m_kon, m_koff, m_endx, m_flg;
    int         m_st [8];
    logic [7:0] e_start, e_rel;

    function automatic logic [7:0] m_keyed();
        logic [7:0] k = '0;
        for (int n = 0; n < 8; n++) k[n] = (m_st[n] == 1);
        return k;
    endfunction

    function automatic logic [7:0] m_read(input logic [6:0] a);
        case ({1'b0, a})
            A_KON:   return m_kon;
            A_KOFF:  return m_koff;
            A_FLG:   return m_flg;
            A_ENDX:  return m_endx;
            default: return m_reg[a];
        endcase
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic m_write(input logic we, input logic [7:0] a, input logic [7:0] d,
                           input logic [7:0] ve);
        logic [6:0] l = a[6:0];
        e_start = '0;
        e_rel   = '0;
        if (we && !a[7]) begin
            case ({1'b0, l})
                A_KON: begin
                    for (int n = 0; n < 8; n++)
                        if (d[n]) begin
                            if (!m_koff[n]) begin m_st[n] = 1; e_start[n] = 1'b1; end
                            else m_st[n] = 2;
                        end
                    m_kon = d;
                end
                A_KOFF: begin
                    for (int n = 0; n < 8; n++) begin
                        if (d[n] && m_st[n] == 1) begin
                            m_st[n] = 0; e_rel[n] = 1'b1; m_kon[n] = 1'b0;
                        end else if (!d[n] && m_st[n] == 2) begin
                            m_st[n] = 1; e_start[n] = 1'b1;
                        end
                    end
                    m_koff = d;
                end
                A_ENDX: m_endx = '0;
                A_FLG: begin
                    if (d[7]) begin
                        m_flg = 8'h60 | {3'b000, d[4:0]};
                        m_kon = '0; m_koff = '0; m_endx = '0;
                        for (int n = 0; n < 8; n++) m_st[n] = 0;
                        e_rel = 8'hFF;
                    end else m_flg = d;
                end
                default: m_reg[l] = d;
            endcase
        end
        m_endx = (m_endx & ~e_start) | ve;
    endtask

    // one bus cycle, then pulse and keyed checks
    task automatic op(input string tag, input logic we, input logic [7:0] a,
                      input logic [7:0] d, input logic [7:0] ve);
        @(negedge clk);
        wr_en = we; reg_addr = a; wr_data = d; voice_end = ve;
        m_write(we, a, d, ve);
        @(negedge clk);
        wr_en = 1'b0; voice_end = '0;
        chk({tag, " start"}, voice_start, e_start);
        chk({tag, " release"}, voice_release, e_rel);
        chk({tag, " keyed"}, voice_keyed, m_keyed());
    endtask

    task automatic rd(input string tag, input logic [7:0] a);
        reg_addr = a;
        #1;
        chk({tag, " read"}, rd_data, m_read(a[6:0]));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 128; i++) m_reg[i] = '0;
        m_kon = '0; m_koff = '0; m_endx = '0; m_flg = 8'h60;
        for (int n = 0; n < 8; n++) m_st[n] = 0;
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 keyed", voice_keyed, 8'h00);
        chk("R1 start", voice_start, 8'h00);
        rd("R1 kon", A_KON); rd("R1 koff", A_KOFF); rd("R1 endx", A_ENDX);
        rd("R1 flg", A_FLG); rd("R1 plain", 8'h13);
        chk("R1 flg value", rd_data, 8'h00);
        reg_addr = A_FLG; #1; chk("R1 flg 0x60", rd_data, 8'h60);

        // R3 plain storage
        op("R3", 1'b1, 8'h2A, 8'h5A, 8'h00); rd("R3", 8'h2A);
        // R2 high-address write ignored, read aliases low location
        op("R2", 1'b1, 8'hAA, 8'h77, 8'h00); rd("R2", 8'h2A); rd("R2 alias", 8'hAA);
        op("R2 kon", 1'b1, 8'hCC, 8'hFF, 8'h00); rd("R2 kon", A_KON);
        // R10 end pulses
        op("R10", 1'b0, 8'h00, 8'h00, 8'h81); rd("R10", A_ENDX);
        // R4 key-on, clears end flag bit 0
        op("R4", 1'b1, A_KON, 8'h01, 8'h00); rd("R4 endx", A_ENDX);
        // R13 pulse drops
        op("R13", 1'b0, 8'h00, 8'h00, 8'h00);
        // R6 release
        op("R6", 1'b1, A_KOFF, 8'h01, 8'h00); rd("R6 kon", A_KON);
        rd("R8 koff", A_KOFF);
        // R5 deferred key-on
        op("R5", 1'b1, A_KON, 8'h01, 8'h00);
        // R7 resume on key-off clear, with end flag set beforehand
        op("R7 pre", 1'b0, 8'h00, 8'h00, 8'h01);
        op("R7", 1'b1, A_KOFF, 8'h00, 8'h00); rd("R7 endx", A_ENDX); rd("R7 koff", A_KOFF);
        // R10 end pulse colliding with start and with end-flag write
        op("R10 vs start", 1'b1, A_KON, 8'h04, 8'h04); rd("R10 vs start", A_ENDX);
        op("R9", 1'b1, A_ENDX, 8'hFF, 8'h00); rd("R9", A_ENDX);
        op("R10 vs clear", 1'b1, A_ENDX, 8'hFF, 8'h10); rd("R10 vs clear", A_ENDX);
        // R12 plain flag write
        op("R12", 1'b1, A_FLG, 8'h1F, 8'h00); rd("R12", A_FLG);
        // R11 soft reset with keyed and pending voices
        op("R11 pre", 1'b1, A_KOFF, 8'h20, 8'h00);
        op("R11 pre", 1'b1, A_KON, 8'hF0, 8'h00);
        op("R11", 1'b1, A_FLG, 8'h9A, 8'h00);
        rd("R11 flg", A_FLG); rd("R11 kon", A_KON); rd("R11 koff", A_KOFF); rd("R11 endx", A_ENDX);

        // constrained random mix
        for (int i = 0; i < 3000; i++) begin
            logic [7:0] a, d, ve;
            int sel = int'($urandom_range(0, 9));
            d  = 8'($urandom);
            ve = ($urandom_range(0, 5) == 0) ? 8'($urandom) : 8'h00;
            case (sel)
                0, 1, 2: a = A_KON;
                3, 4, 5: a = A_KOFF;
                6:       a = A_ENDX;
                7: begin a = A_FLG; if ($urandom_range(0, 3) != 0) d[7] = 1'b0; end
                default: a = 8'($urandom);
            endcase
            op("RND", ($urandom_range(0, 7) != 0), a, d, ve);
            case ($urandom_range(0, 4))
                0: rd("RND", A_KON);
                1: rd("RND", A_KOFF);
                2: rd("RND", A_ENDX);
                3: rd("RND", A_FLG);
                default: rd("RND", 8'($urandom));
            endcase
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end
endmodule